// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a group of power domains on and off under software control through a small 32-bit register bus. Software first stores a domain mask in a power-up mask register or a power-down mask register. It then writes a fixed three-word unlock command to a single command register. Only a command that is complete and in the right order makes the block apply the mask. A bad command changes no domain.

After a valid command, the chosen domains change state once a programmable settle delay has run out. The block then drives its per-domain enable outputs and updates a current-mode register that software can poll. Completion and failures are latched in a status register that software clears by writing ones. Each status cause can be masked before it reaches the single level interrupt output.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, all domain enables are 0, the irq output is 0, status (0x8C) reads 0, the interrupt mask (0x48) reads 0x1FF, the settle register (0x58) reads DEF_SETTLE, and both mask registers (0x0C, 0x10) read 0. An unmapped offset reads 0.
- R2: The command register sits at offset 0x44. Three consecutive command writes of exactly 0xFF, 0x05, 0x50 (compared as full 32-bit words) turn on every domain whose bit is set in the power-up mask (0x0C, bit i = domain i).
- R3: Three consecutive command writes of exactly 0xFF, 0x0A, 0xA0 turn off every domain whose bit is set in the power-down mask (0x10).
- R4: A command write that does not fit the expected order returns the detector to idle, sets status bit 2 and changes no domain. A write of 0xFF is never a failure and always restarts the sequence, even in the middle of a command.
- R5: Bus writes to other offsets between command words do not disturb the sequence. The mask that is applied is the one held at the edge that accepts the final command word.
- R6: With settle value N (offset 0x58), the domain outputs and the current-mode register (0x80) change at the (N+1)th rising edge after the edge that accepts the final command word, and not before.
- R7: Status bit 0 (sequence done) is set at the same edge on which the domains change.
- R8: A power-up mask that names a domain which is already on leaves it on. A power-down mask that names a domain which is already off leaves it off. Both requests still complete and set bit 0.
- R9: A command completed while an earlier change is still pending (up to and including its landing edge) is dropped and sets status bit 3. The earlier change lands unaffected.
- R10: Writing ones to status (0x8C) clears those bits. When a bit is set and cleared on the same edge, the set wins.
- R11: irq is high exactly when some status bit is 1 and its mask bit (0x48) is 0. A mask bit of 1 disables that cause.
- R12: Status bits 1 and 8:4 have no source in this block and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte offset of the register access |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| irq | output | 1 | Level interrupt |
| domOn | output | NUM_DOM | Per-domain power enables |

## Verification
A wrong detector state shows at the ports on the edge of the final command word. A domain then changes without a valid unlock, or fails to change, and status bit 2 or bit 0 disagrees with the model no later than N+1 cycles after that word. A settle counter that is off by one moves the edge at which domOn changes. Because the bench samples every cycle of the window, this shows up within that same window. A wrong status merge shows on the next read of 0x8C or at once on irq.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int STAT_W = 9;
  // register offsets
  localparam int OFF_UPMASK  = 'h0C;
  localparam int OFF_DNMASK  = 'h10;
  localparam int OFF_CMD     = 'h44;
  localparam int OFF_IMASK   = 'h48;
  localparam int OFF_SETTLE  = 'h58;
  localparam int OFF_MODE    = 'h80;
  localparam int OFF_STATUS  = 'h8C;
  // unlock words
  localparam logic [31:0] CMD_ARM  = 32'hFF;
  localparam logic [31:0] CMD_UP1  = 32'h05;
  localparam logic [31:0] CMD_UP2  = 32'h50;
  localparam logic [31:0] CMD_DN1  = 32'h0A;
  localparam logic [31:0] CMD_DN2  = 32'hA0;
  // status bit positions
  localparam int ST_DONE  = 0;
  localparam int ST_ORDER = 2;
  localparam int ST_BUSY  = 3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ARM, SQ_UP, SQ_DN} seqState_t;

  typedef struct packed {
    logic wrUpMask;
    logic wrDnMask;
    logic wrIntMask;
    logic wrSettle;
    logic clrStatus;
    logic goUp;
    logic goDn;
    logic seqFail;
  } seqStrobe_t;
endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output seqStrobe_t        strb
);
  seqState_t seqState, seqNext;
  logic cmdWr;

  assign cmdWr = wrEn && (addr == ADDR_W'(OFF_CMD));

  always_comb begin
    strb = '0;
    strb.wrUpMask  = wrEn && (addr == ADDR_W'(OFF_UPMASK));
    strb.wrDnMask  = wrEn && (addr == ADDR_W'(OFF_DNMASK));
    strb.wrIntMask = wrEn && (addr == ADDR_W'(OFF_IMASK));
    strb.wrSettle  = wrEn && (addr == ADDR_W'(OFF_SETTLE));
    strb.clrStatus = wrEn && (addr == ADDR_W'(OFF_STATUS));
    seqNext = seqState;
    if (cmdWr) begin
      if (wrData == CMD_ARM) begin
        seqNext = SQ_ARM;
      end else begin
        seqNext = SQ_IDLE;
        unique case (seqState)
          SQ_ARM: begin
            if (wrData == CMD_UP1)      seqNext = SQ_UP;
            else if (wrData == CMD_DN1) seqNext = SQ_DN;
            else                        strb.seqFail = 1'b1;
          end
          SQ_UP: begin
            if (wrData == CMD_UP2) strb.goUp = 1'b1;
            else                   strb.seqFail = 1'b1;
          end
          SQ_DN: begin
            if (wrData == CMD_DN2) strb.goDn = 1'b1;
            else                   strb.seqFail = 1'b1;
          end
          default: strb.seqFail = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqState <= SQ_IDLE;
    else       seqState <= seqNext;
  end

  // R4
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.goUp, strb.goDn, strb.seqFail}));
  // R2
  go_returns_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.goUp || strb.goDn) |=> (seqState == SQ_IDLE));
  // R5
  other_write_keeps_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWr |=> $stable(seqState));
endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_DOM    = 8,
  parameter int CNT_W      = 8,
  parameter int DEF_SETTLE = 3,
  parameter int WD_W       = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WD_W-1:0]    wdLow,
  output logic [31:0]        rdData,
  output logic               irq,
  output logic [NUM_DOM-1:0] domOn
);
  logic [NUM_DOM-1:0] upMaskQ, dnMaskQ, curModeQ, pendQ;
  logic [STAT_W-1:0]  intMaskQ, statusQ, setV, clrV;
  logic [CNT_W-1:0]   settleQ, cntQ;
  logic               busyQ, pendUpQ, landNow, goAny;

  assign goAny   = strb.goUp || strb.goDn;
  assign landNow = busyQ && (cntQ == '0);

  always_comb begin
    setV = '0;
    setV[ST_DONE]  = landNow;
    setV[ST_ORDER] = strb.seqFail;
    setV[ST_BUSY]  = goAny && busyQ;
    clrV = strb.clrStatus ? wdLow[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upMaskQ  <= '0;
      dnMaskQ  <= '0;
      intMaskQ <= '1;
      settleQ  <= CNT_W'(DEF_SETTLE);
      statusQ  <= '0;
    end else begin
      if (strb.wrUpMask)  upMaskQ  <= wdLow[NUM_DOM-1:0];
      if (strb.wrDnMask)  dnMaskQ  <= wdLow[NUM_DOM-1:0];
      if (strb.wrIntMask) intMaskQ <= wdLow[STAT_W-1:0];
      if (strb.wrSettle)  settleQ  <= wdLow[CNT_W-1:0];
      statusQ <= (statusQ & ~clrV) | setV;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cntQ     <= '0;
      pendQ    <= '0;
      pendUpQ  <= 1'b0;
      curModeQ <= '0;
    end else if (goAny && !busyQ) begin
      busyQ   <= 1'b1;
      cntQ    <= settleQ;
      pendQ   <= strb.goUp ? upMaskQ : dnMaskQ;
      pendUpQ <= strb.goUp;
    end else if (landNow) begin
      busyQ    <= 1'b0;
      curModeQ <= pendUpQ ? (curModeQ | pendQ) : (curModeQ & ~pendQ);
    end else if (busyQ) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_W'(OFF_UPMASK): rdData[NUM_DOM-1:0] = upMaskQ;
      ADDR_W'(OFF_DNMASK): rdData[NUM_DOM-1:0] = dnMaskQ;
      ADDR_W'(OFF_IMASK):  rdData[STAT_W-1:0]  = intMaskQ;
      ADDR_W'(OFF_SETTLE): rdData[CNT_W-1:0]   = settleQ;
      ADDR_W'(OFF_MODE):   rdData[NUM_DOM-1:0] = curModeQ;
      ADDR_W'(OFF_STATUS): rdData[STAT_W-1:0]  = statusQ;
      default:             rdData = '0;
    endcase
  end

  assign irq   = |(statusQ & ~intMaskQ);
  assign domOn = curModeQ;

  // R6
  mode_only_on_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    !landNow |=> $stable(curModeQ));
  // R7
  done_on_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    landNow |=> statusQ[ST_DONE]);
  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goAny && busyQ) |=> statusQ[ST_BUSY]);
  // R12
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[1] == 1'b0) && (statusQ[8:4] == '0));
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pwrseq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_DOM    = 8,
  parameter int CNT_W      = 8,
  parameter int DEF_SETTLE = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irq,
  output logic [NUM_DOM-1:0] domOn
);
  localparam int WD_A = (NUM_DOM > STAT_W) ? NUM_DOM : STAT_W;
  localparam int WD_W = (CNT_W > WD_A) ? CNT_W : WD_A;

  seqStrobe_t strb;

  pwrseq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .strb(strb)
  );

  pwrseq_dp #(
    .ADDR_W(ADDR_W), .NUM_DOM(NUM_DOM), .CNT_W(CNT_W),
    .DEF_SETTLE(DEF_SETTLE), .WD_W(WD_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr),
    .wdLow(wrData[WD_W-1:0]), .rdData(rdData), .irq(irq), .domOn(domOn)
  );
endmodule

// File: tb/pwr_domain_seq_tb_top.sv
module pwr_domain_seq_tb_top;
  localparam int NUM_DOM = 8;
  localparam int DEF_SETTLE = 3;
  localparam logic [7:0] A_UP = 8'h0C, A_DN = 8'h10, A_CMD = 8'h44,
    A_IM = 8'h48, A_SET = 8'h58, A_MODE = 8'h80, A_ST = 8'h8C;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, irq;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0, rdData, rv;
  logic [NUM_DOM-1:0] domOn, expMode = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_domain_seq #(.NUM_DOM(NUM_DOM), .DEF_SETTLE(DEF_SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irq(irq), .domOn(domOn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1; wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdData;
  endtask

  task automatic seqUp(); busWr(A_CMD, 32'hFF); busWr(A_CMD, 32'h05); busWr(A_CMD, 32'h50); endtask
  task automatic seqDn(); busWr(A_CMD, 32'hFF); busWr(A_CMD, 32'h0A); busWr(A_CMD, 32'hA0); endtask
  task automatic idle(input int n); repeat (n) @(posedge clk); #1; endtask

  // watch every edge of the settle window after the last command word
  task automatic window(input string req, input int n, input logic [NUM_DOM-1:0] oldM,
                        input logic [NUM_DOM-1:0] newM);
    for (int k = 1; k <= n + 1; k++) begin
      @(posedge clk); #1;
      chk(req, 32'(domOn), 32'(k <= n ? oldM : newM));
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NUM_DOM-1:0] m, oldM;
    idle(2); rstN = 1'b1; idle(1);
    // R1 reset state
    chk("R1 domOn", 32'(domOn), 0);
    chk("R1 irq", 32'(irq), 0);
    busRd(A_ST, rv);  chk("R1 status", rv, 0);
    busRd(A_IM, rv);  chk("R1 mask", rv, 32'h1FF);
    busRd(A_SET, rv); chk("R1 settle", rv, DEF_SETTLE);
    busRd(A_UP, rv);  chk("R1 upmask", rv, 0);
    busRd(A_DN, rv);  chk("R1 dnmask", rv, 0);
    busRd(8'h30, rv); chk("R1 unmapped", rv, 0);

    // R2 R3 R6 R7 R8: sweep settle values and mask patterns
    for (int n = 0; n < 6; n++) begin
      busWr(A_SET, n);
      m = NUM_DOM'((n * 37 + 5) & 8'hFF);
      busWr(A_UP, 32'(m)); busWr(A_ST, 32'h1FF);
      oldM = expMode; expMode = expMode | m;
      seqUp(); window("R2 R6 R8 up", n, oldM, expMode);
      busRd(A_MODE, rv); chk("R6 mode reg", rv, 32'(expMode));
      busRd(A_ST, rv);   chk("R7 done", rv, 32'h1);
      m = NUM_DOM'((n * 91 + 3) & 8'hFF);
      busWr(A_DN, 32'(m)); busWr(A_ST, 32'h1FF);
      oldM = expMode; expMode = expMode & ~m;
      seqDn(); window("R3 R6 R8 dn", n, oldM, expMode);
      busRd(A_ST, rv);   chk("R7 done dn", rv, 32'h1);
    end

    // R8: fully already-on request still completes
    busWr(A_SET, 1); busWr(A_UP, 32'(expMode)); busWr(A_ST, 32'h1FF);
    seqUp(); idle(3);
    chk("R8 unchanged", 32'(domOn), 32'(expMode));
    busRd(A_ST, rv); chk("R8 done", rv, 1);

    // R4: order breaks
    busWr(A_ST, 32'h1FF); busWr(A_UP, 32'hFF); busWr(A_DN, 32'hFF);
    busWr(A_CMD, 32'h05); idle(4);
    busRd(A_ST, rv); chk("R4 idle bad word", rv, 32'h4);
    busWr(A_ST, 32'h1FF);
    busWr(A_CMD, 32'hFF); busWr(A_CMD, 32'h05); busWr(A_CMD, 32'h51); idle(4);
    chk("R4 no change", 32'(domOn), 32'(expMode));
    busRd(A_ST, rv); chk("R4 flag", rv, 32'h4);
    busWr(A_ST, 32'h1FF);
    busWr(A_CMD, 32'hFF); busWr(A_CMD, 32'h10A); idle(4);
    busRd(A_ST, rv); chk("R4 full word compare", rv, 32'h4);
    busWr(A_ST, 32'h1FF);
    busWr(A_CMD, 32'hFF); busWr(A_CMD, 32'h05); busWr(A_CMD, 32'hFF);
    busWr(A_CMD, 32'h0A); busWr(A_CMD, 32'hA0); idle(4);
    expMode = '0;
    chk("R4 restart dn", 32'(domOn), 0);
    busRd(A_ST, rv); chk("R4 restart no fail", rv, 32'h1);

    // R5: foreign writes between words; last mask wins
    busWr(A_ST, 32'h1FF); busWr(A_UP, 32'h0F);
    busWr(A_CMD, 32'hFF); busWr(A_UP, 32'h3C); busWr(A_CMD, 32'h05);
    busWr(A_SET, 2); busWr(A_CMD, 32'h50);
    window("R5 interleave", 2, 8'h00, 8'h3C);
    expMode = 8'h3C;
    busRd(A_ST, rv); chk("R5 status", rv, 32'h1);

    // R9: second command while pending
    busWr(A_ST, 32'h1FF); busWr(A_SET, 20); busWr(A_UP, 32'hC1); busWr(A_DN, 32'h3C);
    seqUp(); seqDn(); idle(25);
    expMode = 8'hFD;
    chk("R9 first lands", 32'(domOn), 32'(expMode));
    busRd(A_ST, rv); chk("R9 busy flag", rv, 32'h9);

    // R10: set wins over clear on the landing edge
    busWr(A_SET, 2); busWr(A_UP, 32'h02);
    seqUp(); idle(2); busWr(A_ST, 32'h1);
    busRd(A_ST, rv); chk("R10 set wins", rv, 32'h9);
    busWr(A_ST, 32'h8);
    busRd(A_ST, rv); chk("R10 w1c partial", rv, 32'h1);

    // R11: mask gating
    chk("R11 masked", 32'(irq), 0);
    busWr(A_IM, 32'h1FE); #1; chk("R11 enabled", 32'(irq), 1);
    busWr(A_IM, 32'h1FB); #1; chk("R11 other enabled", 32'(irq), 0);
    busWr(A_IM, 32'h000); busWr(A_ST, 32'h1); #1;
    chk("R11 cleared", 32'(irq), 0);

    // R12: unused bits never set, even after writes
    busWr(A_CMD, 32'h33); busRd(A_ST, rv);
    chk("R12 unused zero", rv & 32'h1F2, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule